// File: doc/BRIEF.md
# Banked 64-bit Integer Register File

This block is the integer register file of a 64-bit processor core. It stores thirty-one general registers of 64 bits. It has two read ports and one write port. On every port, a view bit selects full 64-bit access or access to the low 32 bits only. Narrow reads return the low half with zeros above it. Narrow writes clear the upper half of the target.

Index 31 is not a stored general register. Each port carries its own control bit that decides what index 31 means. When the bit is clear, index 31 is a zero register: it always reads as zero and swallows writes. When the bit is set, index 31 reaches the active stack pointer.

There are four stack pointer copies, one per privilege level. A select input picks the level-0 copy or the copy of the current level. The program counter cannot be reached through any index. Reads are combinational. Writes commit on the rising clock edge.

Top module: `banked_regfile`

## Requirements
- R1: A write with wr_en=1, wr_w64=1 and index 0..30 stores all 64 bits. A 64-bit read of that index on either port returns the stored value after the next rising edge.
- R2: A narrow read (view bit 0) returns bits [31:0] of the target with bits [63:32] forced to zero. It never modifies the stored register.
- R3: A narrow write (wr_w64=0) stores wr_data[31:0] and clears bits [63:32]. Writing 0xFFFFFFFF this way leaves 0x00000000FFFFFFFF.
- R4: Index 31 with the port's SP bit at 0 reads as zero in both views. Writes to it change no general register and no stack pointer copy.
- R5: Index 31 with the port's SP bit at 1 reads or writes the active stack pointer copy, with the same 32/64-bit view rules as R2 and R3.
- R6: The active stack pointer copy is the level-0 copy when sp_sel=0. When sp_sel=1, it is the copy numbered by cur_lvl (0..3). Each of the four copies holds its value independently.
- R7: When a read and the write target the same location in the same cycle, the read returns the old value. The new value is visible after the rising edge.
- R8: The two read ports decode index, view and SP bit independently of each other.
- R9: Reset (rst_n=0, asynchronous) clears all general registers and all stack pointer copies to zero.
- R10: A cycle with wr_en=0 changes no stored value, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_lvl | input | 2 | Current privilege level |
| sp_sel | input | 1 | 0: level-0 stack pointer, 1: current level's stack pointer |
| ra_idx | input | 5 | Read port A index |
| ra_w64 | input | 1 | Read port A view, 1 = 64-bit |
| ra_r31sp | input | 1 | Read port A: index 31 means stack pointer |
| ra_data | output | 64 | Read port A data |
| rb_idx | input | 5 | Read port B index |
| rb_w64 | input | 1 | Read port B view, 1 = 64-bit |
| rb_r31sp | input | 1 | Read port B: index 31 means stack pointer |
| rb_data | output | 64 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write index |
| wr_w64 | input | 1 | Write view, 1 = 64-bit |
| wr_r31sp | input | 1 | Write: index 31 means stack pointer |
| wr_data | input | 64 | Write data |

## Verification
A wrong stored bit shows up on the next read of that index, in the same cycle the index is presented. A missed zero-fill shows up as nonzero upper bits on the first 64-bit read after a narrow write. A wrong level decode shows up as another level's value when the stack pointer is read under a different cur_lvl or sp_sel. Because every location is swept through both ports in both views after each write phase, corruption of any register or stack pointer copy surfaces within one sweep.

// File: rtl/rf_pkg.sv
package rf_pkg;
   typedef enum logic [1:0] {
      TGT_GPR = 2'd0,
      TGT_ZR  = 2'd1,
      TGT_SP  = 2'd2
   } tgt_e;

   function automatic tgt_e classify(input logic is_top, input logic top_is_sp);
      if (!is_top)
         return TGT_GPR;
      return top_is_sp ? TGT_SP : TGT_ZR;
   endfunction
endpackage

// File: rtl/rf_gpr_array.sv
module rf_gpr_array #(
   parameter int XLEN = 64,
   parameter int NREG = 31,
   parameter int IDXW = 5,
   parameter int NRD  = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [IDXW-1:0]            waddr,
   input  logic [XLEN-1:0]            wdata,
   input  logic [NRD-1:0][IDXW-1:0]   raddr,
   output logic [NRD-1:0][XLEN-1:0]   rdata
);
   logic [XLEN-1:0] mem [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[g] <= '0;
         else if (we && waddr == IDXW'(g))
            mem[g] <= wdata;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      always_comb begin
         rdata[p] = '0;
         for (int k = 0; k < NREG; k++)
            if (raddr[p] == IDXW'(k))
               rdata[p] = mem[k];
      end
   end
endmodule

// File: rtl/rf_sp_bank.sv
module rf_sp_bank #(
   parameter int XLEN = 64,
   parameter int NLVL = 4,
   parameter int LVLW = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [LVLW-1:0] lvl,
   input  logic [XLEN-1:0] wdata,
   output logic [XLEN-1:0] rdata
);
   logic [XLEN-1:0] sp_q [NLVL];

   for (genvar l = 0; l < NLVL; l++) begin : g_lvl
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            sp_q[l] <= '0;
         else if (we && lvl == LVLW'(l))
            sp_q[l] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < NLVL; k++)
         if (lvl == LVLW'(k))
            rdata = sp_q[k];
   end
endmodule

// File: rtl/rf_view_mux.sv
module rf_view_mux
   import rf_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  tgt_e            tgt,
   input  logic            w64,
   input  logic [XLEN-1:0] gpr_val,
   input  logic [XLEN-1:0] sp_val,
   output logic [XLEN-1:0] dout
);
   localparam int HALF = XLEN / 2;
   logic [XLEN-1:0] raw;

   always_comb begin
      unique case (tgt)
         TGT_GPR: raw = gpr_val;
         TGT_SP:  raw = sp_val;
         default: raw = '0;
      endcase
      dout = w64 ? raw : {{(XLEN-HALF){1'b0}}, raw[HALF-1:0]};
   end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
   import rf_pkg::*;
#(
   parameter int XLEN = 64,
   parameter int NLVL = 4,
   parameter int IDXW = 5,
   parameter int LVLW = $clog2(NLVL)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [LVLW-1:0] cur_lvl,
   input  logic            sp_sel,
   input  logic [IDXW-1:0] ra_idx,
   input  logic            ra_w64,
   input  logic            ra_r31sp,
   output logic [XLEN-1:0] ra_data,
   input  logic [IDXW-1:0] rb_idx,
   input  logic            rb_w64,
   input  logic            rb_r31sp,
   output logic [XLEN-1:0] rb_data,
   input  logic            wr_en,
   input  logic [IDXW-1:0] wr_idx,
   input  logic            wr_w64,
   input  logic            wr_r31sp,
   input  logic [XLEN-1:0] wr_data
);
   localparam int NRD    = 2;
   localparam int NREG   = (1 << IDXW) - 1;
   localparam int HALF   = XLEN / 2;
   localparam logic [IDXW-1:0] TOP_IDX = {IDXW{1'b1}};

   if (XLEN < 2 || (XLEN % 2) != 0) begin : g_bad_xlen
      $error("XLEN must be even and at least 2");
   end
   if (NLVL != (1 << LVLW)) begin : g_bad_lvl
      $error("NLVL must equal 2**LVLW");
   end

   logic [LVLW-1:0] act_lvl;
   assign act_lvl = sp_sel ? cur_lvl : '0;

   tgt_e            wtgt;
   logic [XLEN-1:0] wval;
   assign wtgt = classify(wr_idx == TOP_IDX, wr_r31sp);
   assign wval = wr_w64 ? wr_data : {{(XLEN-HALF){1'b0}}, wr_data[HALF-1:0]};

   logic [NRD-1:0][IDXW-1:0] rd_idx;
   logic [NRD-1:0]           rd_w64;
   logic [NRD-1:0]           rd_sp;
   logic [NRD-1:0][XLEN-1:0] gpr_rd;
   logic [NRD-1:0][XLEN-1:0] port_out;
   logic [XLEN-1:0]          sp_rd;

   assign rd_idx = {rb_idx, ra_idx};
   assign rd_w64 = {rb_w64, ra_w64};
   assign rd_sp  = {rb_r31sp, ra_r31sp};

   rf_gpr_array #(.XLEN(XLEN), .NREG(NREG), .IDXW(IDXW), .NRD(NRD)) u_gpr (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en && wtgt == TGT_GPR),
      .waddr (wr_idx),
      .wdata (wval),
      .raddr (rd_idx),
      .rdata (gpr_rd)
   );

   rf_sp_bank #(.XLEN(XLEN), .NLVL(NLVL), .LVLW(LVLW)) u_sp (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en && wtgt == TGT_SP),
      .lvl   (act_lvl),
      .wdata (wval),
      .rdata (sp_rd)
   );

   for (genvar p = 0; p < NRD; p++) begin : g_port
      rf_view_mux #(.XLEN(XLEN)) u_mux (
         .tgt     (classify(rd_idx[p] == TOP_IDX, rd_sp[p])),
         .w64     (rd_w64[p]),
         .gpr_val (gpr_rd[p]),
         .sp_val  (sp_rd),
         .dout    (port_out[p])
      );
   end

   assign ra_data = port_out[0];
   assign rb_data = port_out[1];
endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
   parameter int XLEN = 64,
   parameter int IDXW = 5,
   parameter int LVLW = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic [LVLW-1:0] cur_lvl,
   input logic            sp_sel,
   input logic [IDXW-1:0] ra_idx,
   input logic            ra_w64,
   input logic            ra_r31sp,
   input logic [XLEN-1:0] ra_data,
   input logic [IDXW-1:0] rb_idx,
   input logic            rb_w64,
   input logic            rb_r31sp,
   input logic [XLEN-1:0] rb_data,
   input logic            wr_en,
   input logic [IDXW-1:0] wr_idx,
   input logic            wr_w64,
   input logic            wr_r31sp,
   input logic [XLEN-1:0] wr_data
);
   localparam int HALF = XLEN / 2;
   localparam logic [IDXW-1:0] TOP = {IDXW{1'b1}};

   AST_ZR_PORT_A: assert property (@(posedge clk) disable iff (!rst_n)
      (ra_idx == TOP && !ra_r31sp) |-> (ra_data == '0)); // R4
   AST_ZR_PORT_B: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_idx == TOP && !rb_r31sp) |-> (rb_data == '0)); // R4
   AST_NARROW_READ_A: assert property (@(posedge clk) disable iff (!rst_n)
      !ra_w64 |-> (ra_data[XLEN-1:HALF] == '0)); // R2
   AST_NARROW_READ_B: assert property (@(posedge clk) disable iff (!rst_n)
      !rb_w64 |-> (rb_data[XLEN-1:HALF] == '0)); // R2
   AST_NARROW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_w64 && wr_idx != TOP) |=>
      (!(ra_idx == $past(wr_idx) && ra_w64) ||
       ra_data == {{(XLEN-HALF){1'b0}}, $past(wr_data[HALF-1:0])})); // R3
   AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=>
      (!($stable(ra_idx) && $stable(ra_w64) && $stable(ra_r31sp) &&
         $stable(cur_lvl) && $stable(sp_sel)) || $stable(ra_data))); // R10
   AST_SP_LVL0_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && ra_idx == TOP && ra_r31sp && !sp_sel) |=>
      (!(ra_idx == TOP && ra_r31sp && !sp_sel && $stable(ra_w64)) ||
       $stable(ra_data))); // R6
endmodule

bind banked_regfile rf_checker #(.XLEN(XLEN), .IDXW(IDXW), .LVLW(LVLW)) u_chk (.*);

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;
   localparam int XLEN = 64;
   localparam int IDXW = 5;
   localparam int LVLW = 2;
   localparam int NREG = 31;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [LVLW-1:0] cur_lvl = '0;
   logic            sp_sel = 1'b0;
   logic [IDXW-1:0] ra_idx = '0, rb_idx = '0, wr_idx = '0;
   logic            ra_w64 = 1'b1, rb_w64 = 1'b1, wr_w64 = 1'b1;
   logic            ra_r31sp = 1'b0, rb_r31sp = 1'b0, wr_r31sp = 1'b0;
   logic            wr_en = 1'b0;
   logic [XLEN-1:0] wr_data = '0;
   logic [XLEN-1:0] ra_data, rb_data;

   int total = 0;
   int bad = 0;
   logic [XLEN-1:0] gold [NREG];
   logic [XLEN-1:0] spm [4];

   always #4 clk = ~clk;

   banked_regfile dut (.*);

   function automatic logic [XLEN-1:0] view(input logic [XLEN-1:0] v, input logic w64);
      return w64 ? v : {32'h0, v[31:0]};
   endfunction

   function automatic logic [XLEN-1:0] expect_rd(input logic [IDXW-1:0] idx,
                                                 input logic w64, input logic sp);
      logic [XLEN-1:0] raw;
      if (idx != 5'd31) raw = gold[idx];
      else if (!sp)     raw = '0;
      else              raw = spm[sp_sel ? cur_lvl : 2'd0];
      return view(raw, w64);
   endfunction

   task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [IDXW-1:0] idx, input logic w64,
                           input logic sp, input logic [XLEN-1:0] d);
      @(negedge clk);
      wr_idx = idx; wr_w64 = w64; wr_r31sp = sp; wr_data = d; wr_en = 1'b1;
      @(posedge clk);
      #1 wr_en = 1'b0;
      if (idx != 5'd31) gold[idx] = view(d, w64);
      else if (sp) spm[sp_sel ? cur_lvl : 2'd0] = view(d, w64);
   endtask

   task automatic sweep(input string req);
      for (int i = 0; i < 32; i++)
         for (int m = 0; m < 4; m++) begin
            @(negedge clk);
            ra_idx = IDXW'(i); ra_w64 = m[0]; ra_r31sp = m[1];
            rb_idx = IDXW'(31 - i); rb_w64 = ~m[0]; rb_r31sp = ~m[1];
            #1;
            chk(req, ra_data, expect_rd(ra_idx, ra_w64, ra_r31sp));
            chk({req, " R8"}, rb_data, expect_rd(rb_idx, rb_w64, rb_r31sp));
         end
   endtask

   initial begin
      #(8 * 200000);
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < NREG; i++) gold[i] = '0;
      for (int l = 0; l < 4; l++) spm[l] = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R9: everything reads zero after reset
      for (int l = 0; l < 4; l++) begin
         cur_lvl = LVLW'(l); sp_sel = 1'b1;
         sweep("R9");
      end
      cur_lvl = '0; sp_sel = 1'b0;

      // R1: full-width writes to every register
      for (int i = 0; i < NREG; i++)
         do_write(IDXW'(i), 1'b1, 1'b0, 64'hA5C3_0000_0000_0000 ^ (64'(i) * 64'h0101_0123_4567_89AB));
      sweep("R1");

      // R3: narrow write of all ones, then odd registers narrow
      do_write(5'd7, 1'b0, 1'b0, 64'hDEAD_BEEF_FFFF_FFFF);
      @(negedge clk); ra_idx = 5'd7; ra_w64 = 1'b1; ra_r31sp = 1'b0; #1;
      chk("R3", ra_data, 64'h0000_0000_FFFF_FFFF);
      for (int i = 1; i < NREG; i += 2)
         do_write(IDXW'(i), 1'b0, 1'b0, {32'hFFFF_FFFF, 32'(i * 32'h1357_9BDF)});
      sweep("R3");

      // R2: narrow reads leave the register unchanged
      @(negedge clk); ra_idx = 5'd4; ra_w64 = 1'b0; #1;
      chk("R2", ra_data, {32'h0, gold[4][31:0]});
      @(negedge clk); ra_w64 = 1'b1; #1;
      chk("R2", ra_data, gold[4]);

      // R5/R6: write each level's stack pointer through the current level
      sp_sel = 1'b1;
      for (int l = 0; l < 4; l++) begin
         cur_lvl = LVLW'(l);
         do_write(5'd31, 1'b1, 1'b1, 64'h5000_0000_0000_1000 + 64'(l) * 64'h0011_0000_0000_0100);
      end
      for (int l = 0; l < 4; l++) begin
         cur_lvl = LVLW'(l);
         sweep("R5 R6");
      end
      // R6: with sp_sel=0 the level-0 copy is used whatever cur_lvl holds
      sp_sel = 1'b0; cur_lvl = 2'd3;
      do_write(5'd31, 1'b0, 1'b1, 64'h1234_5678_0000_0F00);
      chk("R6", spm[0], 64'h0000_0000_0000_0F00);
      sweep("R6");
      sp_sel = 1'b1;
      sweep("R6");

      // R4: writes to the zero register are dropped
      do_write(5'd31, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
      sweep("R4");

      // R7: read-during-write returns the old value
      @(negedge clk);
      ra_idx = 5'd9; ra_w64 = 1'b1; ra_r31sp = 1'b0;
      wr_idx = 5'd9; wr_w64 = 1'b1; wr_r31sp = 1'b0; wr_data = 64'h0BAD_F00D_CAFE_0009; wr_en = 1'b1;
      #1 chk("R7", ra_data, gold[9]);
      @(posedge clk); #1 wr_en = 1'b0; gold[9] = 64'h0BAD_F00D_CAFE_0009;
      chk("R7", ra_data, gold[9]);

      // R10: inactive write inputs change nothing
      @(negedge clk);
      wr_idx = 5'd2; wr_w64 = 1'b1; wr_r31sp = 1'b0; wr_data = 64'hFFFF_0000_FFFF_0000; wr_en = 1'b0;
      @(posedge clk);
      @(negedge clk);
      wr_idx = 5'd31; wr_r31sp = 1'b1;
      @(posedge clk);
      sweep("R10");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule